// File: doc/BRIEF.md
# Two-Bit Serial Register Bus Master

This block turns one parallel register access into a frame on a narrow serial register bus and gathers the reply. A user raises `start_i` with an operation select, a 17-bit address, write data and a width select. The master then holds its request strobe high while it drives one two-bit beat per clock on the request lane. The first beat carries the operation flag together with address bit 0. The remaining address bits follow, and for a write the data follows them.

After the strobe drops, a write finishes when the slave returns one acknowledge pulse. A read collects one two-bit response beat in every cycle that acknowledge is high, until the whole word has arrived. The word is 32 bits in wide mode and 8 bits in narrow mode. A programmable limit on the number of cycles without an acknowledge ends a stuck transaction with a timeout flag. `done_o` pulses once for every accepted request.

Top module: `sbm_master`

## Requirements
- R1: After reset, `req_o`, `busy_o`, `done_o`, `timeout_o`, `lane_o` and `rdata_o` are all zero.
- R2: When `start_i` is high while `busy_o` is low, `req_o` and `busy_o` rise in the next cycle. The first beat on `lane_o` is {addr bit 0, op flag}, with lane bit 0 equal to 1 for a write and 0 for a read.
- R3: Beats 1 to 8 carry the rest of the address, lowest pair first. Beat k is {addr[2k], addr[2k-1]}.
- R4: For a write, data beats follow the address directly. Data beat j is {wdata[2j+1], wdata[2j]}. Narrow mode sends only wdata[7:0].
- R5: `req_o` stays high for exactly 25 consecutive cycles for a wide write, 13 for a narrow write and 9 for a read. `lane_o` is zero whenever `req_o` is low.
- R6: After the strobe falls, the first cycle with `ack_i` high completes a write. `done_o` pulses in the next cycle with `timeout_o` low.
- R7: For a read, each cycle with `ack_i` high captures `rsp_i` as beat j into bits [2j+1:2j]. Gaps between beats are allowed. After 16 beats (wide) or 4 beats (narrow), `done_o` pulses and `rdata_o` shows the word, zero-extended in narrow mode.
- R8: `start_i` is ignored while `busy_o` is high. The frame in progress is unchanged and no extra transaction follows.
- R9: Suppose `tmo_limit_i` = L, with 0 treated as 1. If L consecutive waiting cycles pass with `ack_i` low, the transaction ends and `done_o` and `timeout_o` pulse together. An acknowledge in the L-th cycle still counts, and each acknowledge restarts the count.
- R10: `done_o` is a single-cycle pulse, `busy_o` is low while it is high, and `timeout_o` is high only together with `done_o`. `ack_i` while idle has no effect.
- R11: `rdata_o` changes only in a cycle where `done_o` is high at the end of a successful read. Writes and timeouts leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a transaction |
| write_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 32-bit data, 0 = 8-bit data |
| addr_i | input | 17 | Register address |
| wdata_i | input | 32 | Write data |
| tmo_limit_i | input | 16 | Ack-less cycles before timeout |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Completion was by timeout |
| rdata_o | output | 32 | Last read word |
| req_o | output | 1 | Request strobe |
| lane_o | output | 2 | Request lane |
| ack_i | input | 1 | Slave acknowledge |
| rsp_i | input | 2 | Response lane |

## Verification
Every cycle, the assertions check the strobe run length against the latched operation and width, the content of the first beat, a quiet lane outside the strobe, the single-cycle `done_o`, that `timeout_o` only comes with `done_o`, and that `rdata_o` holds outside completion. Only the bench scenarios can show the full address and data ordering, the reassembly of read words across acknowledge gaps, the exact cycle at which a timeout fires next to an acknowledge that arrives just in time, and that a start pulse during a frame leaves no trace.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } sbm_state_e;
endpackage

// File: rtl/sbm_frame_tx.sv
module sbm_frame_tx #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  localparam int FRM_W = 1 + ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [1:0]        lane_o
);
  logic [FRM_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (load_i) begin
      // bit 0 = op flag, bit 1 = addr[0], so every beat pairs neighbours
      sh_q <= {wdata_i, addr_i, wr_i};
    end else if (shift_i) begin
      sh_q <= {2'b00, sh_q[FRM_W-1:2]};
    end
  end

  assign lane_o = shift_i ? sh_q[1:0] : 2'b00;
endmodule

// File: rtl/sbm_rsp_rx.sv
module sbm_rsp_rx #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  localparam int WIDE_BEATS   = DATA_W / 2,
  localparam int NARROW_BEATS = NARROW_W / 2,
  localparam int IDX_W        = $clog2(WIDE_BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              wide_i,
  input  logic [1:0]        rsp_i,
  output logic [DATA_W-1:0] word_o,
  output logic              last_o
);
  logic [DATA_W-1:0] acc_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (cap_i) begin
      acc_q <= word_o;
      idx_q <= idx_q + 1'b1;
    end
  end

  // word including the beat on the lane this cycle
  always_comb begin
    word_o = acc_q;
    word_o[2*idx_q +: 2] = rsp_i;
  end

  assign last_o = wide_i ? (idx_q == IDX_W'(WIDE_BEATS - 1))
                         : (idx_q == IDX_W'(NARROW_BEATS - 1));
endmodule

// File: rtl/sbm_timer.sv
module sbm_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            run_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // limit 0 expires like limit 1
  assign expire_o = run_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i});
endmodule

// File: rtl/sbm_master.sv
module sbm_master
  import sbm_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  parameter int TO_W     = 16,
  localparam int ADDR_BEATS   = (ADDR_W + 1) / 2,
  localparam int WIDE_BEATS   = DATA_W / 2,
  localparam int NARROW_BEATS = NARROW_W / 2,
  localparam int FRM_MAX      = ADDR_BEATS + WIDE_BEATS,
  localparam int CNT_W        = $clog2(FRM_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [TO_W-1:0]   tmo_limit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              req_o,
  output logic [1:0]        lane_o,
  input  logic              ack_i,
  input  logic [1:0]        rsp_i
);
  sbm_state_e        state_q;
  logic              wr_q, wide_q;
  logic [TO_W-1:0]   lim_q;
  logic [CNT_W-1:0]  beat_q;
  logic [CNT_W-1:0]  last_beat;
  logic              done_q, to_q;
  logic [DATA_W-1:0] rdata_q;

  logic              accept, tx_shift, rx_cap, rx_last, tm_clr, tm_run, tm_exp;
  logic [DATA_W-1:0] rx_word;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign tx_shift = (state_q == ST_SEND);
  assign rx_cap   = (state_q == ST_WAIT) && ack_i && !wr_q;
  assign tm_run   = (state_q == ST_WAIT);
  assign tm_clr   = !tm_run || ack_i;

  always_comb begin
    if (!wr_q)       last_beat = CNT_W'(ADDR_BEATS - 1);
    else if (wide_q) last_beat = CNT_W'(ADDR_BEATS + WIDE_BEATS - 1);
    else             last_beat = CNT_W'(ADDR_BEATS + NARROW_BEATS - 1);
  end

  sbm_frame_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shift_i (tx_shift),
    .wr_i    (write_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .lane_o  (lane_o)
  );

  sbm_rsp_rx #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .cap_i  (rx_cap),
    .wide_i (wide_q),
    .rsp_i  (rsp_i),
    .word_o (rx_word),
    .last_o (rx_last)
  );

  sbm_timer #(.TO_W(TO_W)) u_tm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tm_clr),
    .run_i    (tm_run),
    .limit_i  (lim_q),
    .expire_o (tm_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      lim_q   <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      to_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            wr_q    <= write_i;
            wide_q  <= wide_i;
            lim_q   <= tmo_limit_i;
            beat_q  <= '0;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == last_beat) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ack_i) begin
            if (wr_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (rx_last) begin
              done_q  <= 1'b1;
              rdata_q <= rx_word;
              state_q <= ST_IDLE;
            end
          end else if (tm_exp) begin
            done_q  <= 1'b1;
            to_q    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign req_o     = tx_shift;
  assign done_o    = done_q;
  assign timeout_o = to_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/sbm_master_chk.sv
module sbm_master_chk #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 8,
  localparam int ADDR_BEATS = (ADDR_W + 1) / 2,
  localparam int LEN_W      = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              write_i,
  input logic              wide_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              req_o,
  input logic [1:0]        lane_o
);
  logic             c_wr, c_wide, c_a0;
  logic [LEN_W-1:0] run_q;
  logic [LEN_W-1:0] exp_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_wr <= 1'b0; c_wide <= 1'b0; c_a0 <= 1'b0; run_q <= '0;
    end else begin
      if (start_i && !busy_o) begin
        c_wr <= write_i; c_wide <= wide_i; c_a0 <= addr_i[0];
      end
      run_q <= req_o ? run_q + 1'b1 : '0;
    end
  end

  assign exp_len = LEN_W'(ADDR_BEATS) +
                   (c_wr ? (c_wide ? LEN_W'(DATA_W / 2) : LEN_W'(NARROW_W / 2)) : '0);

  a_r5_strobe_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> run_q == exp_len);
  a_r5_lane_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> lane_o == 2'b00);
  a_r2_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> (lane_o == {c_a0, c_wr}) && busy_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r9_to_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o));
endmodule

bind sbm_master sbm_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .write_i   (write_i),
  .wide_i    (wide_i),
  .addr_i    (addr_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .timeout_o (timeout_o),
  .rdata_o   (rdata_o),
  .req_o     (req_o),
  .lane_o    (lane_o)
);

// File: tb/sbm_master_bench.sv
`timescale 1ns/1ps
module sbm_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wr = 1'b0, wide = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] lim = 16'd20;
  logic        busy, done, tmo, req, ack = 1'b0;
  logic [31:0] rdata;
  logic [1:0]  lane, rsp = 2'b00;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] exp_rdata = '0;

  always #4 clk = ~clk;

  sbm_master u_sbm_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata), .tmo_limit_i(lim), .busy_o(busy),
    .done_o(done), .timeout_o(tmo), .rdata_o(rdata), .req_o(req),
    .lane_o(lane), .ack_i(ack), .rsp_i(rsp)
  );

  typedef struct packed {
    logic        w;
    logic        wd;
    logic [16:0] a;
    logic [31:0] d;
    logic [31:0] r;
    logic [3:0]  gap;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 17'h1A5C3, 32'hDEADBEEF, 32'h0,        4'd0},
    '{1'b0, 1'b1, 17'h00001, 32'h0,        32'h89ABCDEF, 4'd2},
    '{1'b1, 1'b0, 17'h1FFFF, 32'hFFFFFF5A, 32'h0,        4'd1},
    '{1'b0, 1'b0, 17'h10000, 32'h0,        32'hFFFFFF3C, 4'd0},
    '{1'b0, 1'b1, 17'h0AAAA, 32'h0,        32'h00000000, 4'd5},
    '{1'b1, 1'b1, 17'h00000, 32'h12345678, 32'h0,        4'd3}
  };

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_beat(input vec_t v, input int n);
    int j;
    if (n == 0) return {v.a[0], v.w};
    if (n <= 8) return {v.a[2*n], v.a[2*n-1]};
    j = n - 9;
    return {v.d[2*j+1], v.d[2*j]};
  endfunction

  // mode: 0 normal, 1 expect timeout, 2 gap mid-read, 3 poke start during frame
  task automatic run_txn(input vec_t v, input logic [15:0] l, input int mode);
    logic [1:0] beats [64];
    int n, exp_len, k, eff, nb;
    bit bad_a, bad_d, bad_0, early;
    @(negedge clk);
    wr = v.w; wide = v.wd; addr = v.a; wdata = v.d; lim = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req && busy, "R2 strobe/busy rise", {30'd0, req, busy}, 32'h3);
    n = 0;
    while (req && n < 64) begin
      beats[n] = lane;
      n++;
      if (mode == 3 && n == 3) begin
        start = 1'b1; wr = ~v.w; wide = ~v.wd; addr = ~v.a; wdata = ~v.d;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    exp_len = v.w ? (v.wd ? 25 : 13) : 9;
    chk(n == exp_len, "R5 strobe length", n, exp_len);
    chk(lane == 2'b00, "R5 lane quiet", lane, 0);
    bad_0 = 1'b0; bad_a = 1'b0; bad_d = 1'b0;
    for (int i = 0; i < n && i < exp_len; i++) begin
      if (beats[i] != exp_beat(v, i)) begin
        if (i == 0) bad_0 = 1'b1;
        else if (i <= 8) bad_a = 1'b1;
        else bad_d = 1'b1;
      end
    end
    chk(!bad_0, "R2 first beat", beats[0], exp_beat(v, 0));
    chk(!bad_a, "R3 address beats", bad_a, 0);
    if (v.w) chk(!bad_d, "R4 data beats", bad_d, 0);
    if (mode == 1) begin
      k = 1;
      while (!done && k < int'(l) + 10) begin
        @(negedge clk);
        k++;
      end
      eff = (l == 0) ? 1 : int'(l);
      chk(done && tmo, "R9 timeout done", {30'd0, done, tmo}, 32'h3);
      chk(k == eff + 1, "R9 timeout cycle", k, eff + 1);
      chk(rdata == exp_rdata, "R11 rdata kept on timeout", rdata, exp_rdata);
    end else begin
      early = 1'b0;
      repeat (int'(v.gap)) begin
        @(negedge clk);
        if (done) early = 1'b1;
      end
      if (v.w) begin
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(done && !tmo && !busy, "R6 write done", {29'd0, done, tmo, busy}, 32'h4);
        chk(rdata == exp_rdata, "R11 rdata kept on write", rdata, exp_rdata);
      end else begin
        nb = v.wd ? 16 : 4;
        for (int j = 0; j < nb; j++) begin
          ack = 1'b1; rsp = v.r[2*j +: 2];
          @(negedge clk);
          if (j < nb - 1 && done) early = 1'b1;
          if (mode == 2 && j == 1) begin
            ack = 1'b0; rsp = 2'b11;
            repeat (3) begin
              @(negedge clk);
              if (done) early = 1'b1;
            end
          end
        end
        ack = 1'b0; rsp = 2'b00;
        exp_rdata = v.wd ? v.r : {24'd0, v.r[7:0]};
        chk(done && !tmo, "R7 read done", {30'd0, done, tmo}, 32'h2);
        chk(rdata == exp_rdata, "R7 read data", rdata, exp_rdata);
      end
      chk(!early, "R10 no early done", early, 0);
    end
    @(negedge clk);
    chk(!done && !tmo && !busy && !req, "R10 single done pulse",
        {28'd0, done, tmo, busy, req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({req, busy, done, tmo, lane} == 6'd0 && rdata == 32'd0, "R1 reset outputs",
        {26'd0, req, busy, done, tmo, lane}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_txn(VECS[i], 16'd20, 0);
    // read with ack gap between beats
    run_txn('{1'b0, 1'b1, 17'h15555, 32'h0, 32'hA5C3_0F96, 4'd1}, 16'd4, 2);
    // start pulsed during a frame is ignored (R8)
    run_txn('{1'b1, 1'b0, 17'h0F0F0, 32'h0000_00B4, 32'h0, 4'd0}, 16'd20, 3);
    chk(!busy && !req, "R8 no extra transaction", {30'd0, busy, req}, 0);
    // ack arrives in the last allowed cycle (R9)
    run_txn('{1'b1, 1'b1, 17'h00F00, 32'h0BAD_F00D, 32'h0, 4'd3}, 16'd4, 0);
    // timeout on read and on write, limit 0 acts as 1 (R9)
    run_txn('{1'b0, 1'b1, 17'h12345, 32'h0, 32'h0, 4'd0}, 16'd4, 1);
    run_txn('{1'b1, 1'b0, 17'h00042, 32'h0000_0011, 32'h0, 4'd0}, 16'd0, 1);
    // ack while idle (R10)
    @(negedge clk);
    ack = 1'b1; rsp = 2'b11;
    @(negedge clk);
    ack = 1'b0; rsp = 2'b00;
    @(negedge clk);
    chk(!done && !busy && !req, "R10 idle ack ignored", {29'd0, done, busy, req}, 0);
    chk(rdata == exp_rdata, "R11 rdata after idle ack", rdata, exp_rdata);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule